// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a bank of byte-wide configuration registers that a host reaches through two I/O addresses: a config/index port and a data port one address above it. The bank starts out locked. Two back-to-back writes of 55h to the config port unlock it. While unlocked, a byte written to the index port chooses a register, and the data port then reads or writes that register. A write of AAh to the index port locks the bank again.

Most of the bank is reserved. Reserved bits ignore writes and hold fixed values. A device-identity byte and a revision byte are read-only. The other registers drive per-device enable bits, two-bit mode fields and base addresses to the rest of the chip. These outputs stay live while the bank is locked, so the devices they control keep running.

Top module: `cfg_port_bank`

## Requirements
- R1: After reset the bank is locked (`cfg_active`=0), every register holds its default value, the index is 00h, `dev_enable`, `dev_mode` and `dev_base` are all zero, and index 2Ch reads 03h.
- R2: Only writes to the config port address count toward unlocking. Two consecutive writes of 55h there unlock the bank. Any other byte written there after the first 55h cancels the sequence. Data-port writes in between neither cancel the sequence nor take effect.
- R3: While unlocked, a write of AAh to the index port locks the bank in the next cycle and leaves the index unchanged.
- R4: While locked, data-port and index-port writes change no register and no output, and every read returns 00h.
- R5: While unlocked, a write to the index port loads the index (except AAh). A read of the index port returns the current index.
- R6: While unlocked, a read of the data port returns the selected register in the same cycle.
- R7: Index 0Dh always reads 28h and index 0Eh always reads the revision parameter (default 01h). Writes to either have no effect.
- R8: Reserved bits ignore writes. Writing FFh to index 02h reads back 07h, and writing FFh to index 2Ch reads back 0Fh (with three devices).
- R9: Index 06h is a reserved register that reads FFh and ignores writes.
- R10: `dev_enable[i]` is bit i of index 02h. `dev_mode[2i+1:2i]` is bits 2i+1:2i of index 04h. `dev_base[10i+9:10i]` is the byte at index 24h+i followed by two zero bits.
- R11: An index at or above the bank depth (48) reads 00h, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of `bus_rd` |
| cfg_active | output | 1 | High while the bank is unlocked |
| dev_enable | output | N_DEV | Per-device enable bits |
| dev_mode | output | 2*N_DEV | Two-bit mode field per device |
| dev_base | output | 10*N_DEV | 10-bit base address per device |

## Verification
The assertions assume that `bus_wr` lasts a single cycle per host write. They also assume that addresses and data are stable while the clock edge is sampled. Reset must be held for at least one edge. The stimulus drives every strobe from the falling clock edge, raises it for exactly one cycle, and never asserts a read and a write together. Because of that, each write is counted once by the unlock sequencer and once by the register bank. The bench keeps the number of devices at three, so the enable and mode masks stay within one byte.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lock_e;

    localparam logic [7:0] KEY_ENTER = 8'h55;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;
    localparam logic [7:0] ID_VAL    = 8'h28;

    localparam int IX_ENABLE = 8'h02;
    localparam int IX_MODE   = 8'h04;
    localparam int IX_RSV_FF = 8'h06;
    localparam int IX_ID     = 8'h0D;
    localparam int IX_REV    = 8'h0E;
    localparam int IX_BASE0  = 8'h24;
    localparam int IX_PLSEL  = 8'h2C;

    // writable bits of register idx
    function automatic logic [7:0] wmask(input int idx, input int nd);
        logic [7:0] m;
        m = 8'h00;
        if (idx == IX_ENABLE) m = 8'((1 << nd) - 1);
        else if (idx == IX_MODE) m = 8'((1 << (2 * nd)) - 1);
        else if (idx == IX_PLSEL) m = 8'h0F;
        else if (idx >= IX_BASE0 && idx < IX_BASE0 + nd) m = 8'hFF;
        return m;
    endfunction

    // default value of register idx
    function automatic logic [7:0] rstval(input int idx, input logic [7:0] rev);
        logic [7:0] v;
        v = 8'h00;
        if (idx == IX_RSV_FF) v = 8'hFF;
        else if (idx == IX_ID) v = ID_VAL;
        else if (idx == IX_REV) v = rev;
        else if (idx == IX_PLSEL) v = 8'h03;
        return v;
    endfunction
endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    typedef struct packed {
        lock_e st;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            unique case (s_q.st)
                LK_CLOSED: if (wdata == KEY_ENTER) s_d.st = LK_HALF;
                LK_HALF:   s_d.st = (wdata == KEY_ENTER) ? LK_OPEN : LK_CLOSED;
                LK_OPEN:   if (wdata == KEY_EXIT) s_d.st = LK_CLOSED;
                default:   s_d.st = LK_CLOSED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: LK_CLOSED};
        else        s_q <= s_d;
    end

    assign unlocked = (s_q.st == LK_OPEN);

    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && cfg_wr && wdata == KEY_EXIT) |=> !unlocked); // R3

    AST_OPEN_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked ##1 unlocked) |-> $past(s_q.st == LK_HALF && cfg_wr && wdata == KEY_ENTER)); // R2
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfgp_pkg::*;
#(
    parameter int         NREG  = 48,
    parameter int         N_DEV = 3,
    parameter logic [7:0] REV   = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic               data_wr,
    input  logic [7:0]         wdata,
    output logic [7:0]         idx,
    output logic [7:0]         rd_data,
    output logic [N_DEV-1:0]   en_bits,
    output logic [2*N_DEV-1:0] mode_bits,
    output logic [8*N_DEV-1:0] base_bytes
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [7:0]            idx;
        logic [NREG-1:0][7:0]  regs;
    } bank_t;

    bank_t s_d, s_q;
    logic  in_range;

    assign in_range = ({24'd0, s_q.idx} < NREG);

    always_comb begin
        s_d = s_q;
        if (idx_wr) s_d.idx = wdata;
        if (data_wr && in_range) begin
            for (int i = 0; i < NREG; i++) begin
                if (s_q.idx[IW-1:0] == IW'(i))
                    s_d.regs[i] = (s_q.regs[i] & ~wmask(i, N_DEV)) | (wdata & wmask(i, N_DEV));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.idx <= 8'h00;
            for (int i = 0; i < NREG; i++) s_q.regs[i] <= rstval(i, REV);
        end else begin
            s_q <= s_d;
        end
    end

    assign idx     = s_q.idx;
    assign rd_data = in_range ? s_q.regs[s_q.idx[IW-1:0]] : 8'h00;
    assign en_bits   = s_q.regs[IX_ENABLE][N_DEV-1:0];
    assign mode_bits = s_q.regs[IX_MODE][2*N_DEV-1:0];

    for (genvar g = 0; g < N_DEV; g++) begin : g_base
        assign base_bytes[8*g +: 8] = s_q.regs[IX_BASE0 + g];
    end

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.idx == 8'(IX_ID)) |-> rd_data == ID_VAL); // R7

    AST_RSV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        in_range |-> ((rd_data & ~wmask(int'(s_q.idx), N_DEV))
                      == (rstval(int'(s_q.idx), REV) & ~wmask(int'(s_q.idx), N_DEV)))); // R8

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |-> rd_data == 8'h00); // R11
endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h03F0,
    parameter int              NREG     = 48,
    parameter int              N_DEV    = 3,
    parameter logic [7:0]      REV      = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                cfg_active,
    output logic [N_DEV-1:0]    dev_enable,
    output logic [2*N_DEV-1:0]  dev_mode,
    output logic [10*N_DEV-1:0] dev_base
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = CFG_ADDR + 1'b1;

    logic hit_idx, hit_dat, unlocked, idx_wr, data_wr;
    logic [7:0] idx, rd_data;
    logic [8*N_DEV-1:0] base_bytes;

    assign hit_idx = (bus_addr == CFG_ADDR);
    assign hit_dat = (bus_addr == DATA_ADDR);
    assign idx_wr  = bus_wr && hit_idx && unlocked && (bus_wdata != KEY_EXIT);
    assign data_wr = bus_wr && hit_dat && unlocked;

    cfg_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (bus_wr && hit_idx),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    cfg_reg_bank #(.NREG(NREG), .N_DEV(N_DEV), .REV(REV)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .data_wr    (data_wr),
        .wdata      (bus_wdata),
        .idx        (idx),
        .rd_data    (rd_data),
        .en_bits    (dev_enable),
        .mode_bits  (dev_mode),
        .base_bytes (base_bytes)
    );

    for (genvar g = 0; g < N_DEV; g++) begin : g_base
        assign dev_base[10*g +: 10] = {base_bytes[8*g +: 8], 2'b00};
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && unlocked) begin
            if (hit_idx)      bus_rdata = idx;
            else if (hit_dat) bus_rdata = rd_data;
        end
    end

    assign cfg_active = unlocked;

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |=> ($stable(dev_enable) && $stable(dev_mode) && $stable(dev_base))); // R4

    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_active) |-> bus_rdata == 8'h00); // R4
endmodule

// File: tb/tb_cfg_port_bank.sv
module tb_cfg_port_bank;
    localparam int CLK_P = 10;
    localparam logic [15:0] CFG = 16'h03F0;

    logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_addr = 0;
    logic [7:0]  bus_wdata = 0, bus_rdata;
    logic        cfg_active;
    logic [2:0]  dev_enable;
    logic [5:0]  dev_mode;
    logic [29:0] dev_base;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cfg_port_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_active(cfg_active), .dev_enable(dev_enable),
        .dev_mode(dev_mode), .dev_base(dev_base)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        bus_addr = CFG + 16'(port); bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic port, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = CFG + 16'(port); bus_rd = 1;
        #1 chk(tag, 32'(bus_rdata), 32'(exp));
        @(negedge clk);
        bus_rd = 0;
    endtask

    typedef struct packed {
        logic       is_wr;
        logic       port;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [24] = '{
        '{1'b0, 1'b1, 8'h00, 8'h00, 8'd4},  // R4 locked read
        '{1'b1, 1'b0, 8'h55, 8'h00, 8'd2},
        '{1'b1, 1'b0, 8'h12, 8'h00, 8'd2},  // R2 cancel
        '{1'b1, 1'b0, 8'h55, 8'h00, 8'd2},
        '{1'b1, 1'b0, 8'h55, 8'h00, 8'd2},  // R2 open
        '{1'b1, 1'b0, 8'h0D, 8'h00, 8'd5},
        '{1'b0, 1'b1, 8'h00, 8'h28, 8'd7},  // R7 id
        '{1'b1, 1'b1, 8'h5A, 8'h00, 8'd7},
        '{1'b0, 1'b1, 8'h00, 8'h28, 8'd7},  // R7 id unchanged
        '{1'b0, 1'b0, 8'h00, 8'h0D, 8'd5},  // R5 index readback
        '{1'b1, 1'b0, 8'h06, 8'h00, 8'd9},
        '{1'b0, 1'b1, 8'h00, 8'hFF, 8'd9},  // R9
        '{1'b1, 1'b1, 8'h00, 8'h00, 8'd9},
        '{1'b0, 1'b1, 8'h00, 8'hFF, 8'd9},  // R9 unchanged
        '{1'b1, 1'b0, 8'h2C, 8'h00, 8'd1},
        '{1'b0, 1'b1, 8'h00, 8'h03, 8'd1},  // R1 default 03h
        '{1'b1, 1'b1, 8'hFF, 8'h00, 8'd8},
        '{1'b0, 1'b1, 8'h00, 8'h0F, 8'd8},  // R8
        '{1'b1, 1'b0, 8'h02, 8'h00, 8'd8},
        '{1'b1, 1'b1, 8'hFF, 8'h00, 8'd8},
        '{1'b0, 1'b1, 8'h00, 8'h07, 8'd8},  // R8 enable mask
        '{1'b1, 1'b0, 8'h30, 8'h00, 8'd11},
        '{1'b0, 1'b1, 8'h00, 8'h00, 8'd11}, // R11
        '{1'b1, 1'b0, 8'h0E, 8'h00, 8'd7}
    };

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        chk("R1 cfg_active", 32'(cfg_active), 0);
        chk("R1 dev_enable", 32'(dev_enable), 0);
        chk("R1 dev_base", 32'(dev_base), 0);

        foreach (VECS[k]) begin
            if (VECS[k].is_wr) wr(VECS[k].port, VECS[k].dat);
            else rd(VECS[k].port, VECS[k].exp, $sformatf("R%0d vec%0d", VECS[k].req, k));
        end
        rd(1, 8'h01, "R7 revision");
        chk("R10 dev_enable", 32'(dev_enable), 32'h7);

        wr(0, 8'h04); wr(1, 8'hE4);
        chk("R10 dev_mode", 32'(dev_mode), 32'h24);
        rd(1, 8'h24, "R6 mode readback");
        wr(0, 8'h24); wr(1, 8'h81);
        chk("R10 dev_base", 32'(dev_base), 32'h204);

        wr(0, 8'hAA);
        chk("R3 locked after exit", 32'(cfg_active), 0);
        rd(1, 8'h00, "R4 read while locked");
        wr(1, 8'h00);
        chk("R4 write ignored", 32'(dev_base), 32'h204);

        wr(0, 8'h55); wr(1, 8'h00); wr(0, 8'h55);
        chk("R2 data write mid-sequence", 32'(cfg_active), 1);
        rd(0, 8'h24, "R3 index kept");
        rd(1, 8'h81, "R2 base unchanged");

        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        chk("R1 relock", 32'(cfg_active), 0);
        chk("R1 enable cleared", 32'(dev_enable), 0);
        chk("R1 base cleared", 32'(dev_base), 0);
        wr(0, 8'h55); wr(0, 8'h55);
        rd(0, 8'h00, "R1 index default");
        wr(0, 8'h2C);
        rd(1, 8'h03, "R1 register default");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule